// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block sits between a 32-bit register datapath and a memory that is 32 bits wide but addressed by byte. A word at byte address A covers bytes A to A+3, and the next word starts at A+4. For a store, the block turns a byte address, an access size and register data into a word address, four byte-lane write strobes and write data with the bytes moved into their lanes. For a load, it takes the word that memory returns, picks out the addressed byte or halfword and widens it to 32 bits. A flag selects zero-extension or sign-extension.

Lanes are big-endian: the most significant byte of a word sits at the lowest address. For example, 0x000F4240 stored at address 80 leaves 00, 0F, 42, 40 in bytes 80, 81, 82, 83. An access whose address is not a multiple of its size is rejected, and so is an access with the unused size code. The block is purely combinational. Requests and results pass through it within the same cycle.

Top module: `be_lsu_align`

## Requirements
- R1: `word_addr` equals the byte address with its two low bits dropped (`addr >> 2`) for every request.
- R2: Size is coded 2'b00 byte, 2'b01 halfword, 2'b10 word. `misaligned` is high exactly when a halfword has an odd address or a word has `addr[1:0]` not equal to 0. Byte accesses are never misaligned.
- R3: Size code 2'b11 raises `bad_size`, keeps `misaligned` low and rejects the access.
- R4: A rejected access (misaligned or bad size) drives all four `lane_we` bits low and returns 0 on `load_data`.
- R5: A byte store at offset k (`addr[1:0]`) raises only `lane_we[3-k]`. `lane_we[3]` strobes `mem_wdata[31:24]`, the byte at offset 0.
- R6: A halfword store at offset 0 raises `lane_we` = 4'b1100, and at offset 2 raises 4'b0011.
- R7: An aligned word store raises all four `lane_we` bits.
- R8: Store data is replicated: a byte store drives `wdata[7:0]` on all four lanes, a halfword store drives `wdata[15:0]` on both halves, and a word store drives `wdata` unchanged.
- R9: A byte load returns the `mem_rdata` byte at offset k, taken from bits [31-8k:24-8k], in `load_data[7:0]`.
- R10: A halfword load returns `mem_rdata[31:16]` at offset 0 and `mem_rdata[15:0]` at offset 2, in `load_data[15:0]`.
- R11: With `sign_ext` low, the upper bits of a narrow load result are all 0.
- R12: With `sign_ext` high, the upper bits of a narrow load result copy the top bit of the loaded byte or halfword.
- R13: A word load returns `mem_rdata` unchanged, whatever the value of `sign_ext`.
- R14: With `store` low, all `lane_we` bits stay low for every size and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access size code |
| sign_ext | input | 1 | Sign-extend narrow loads when high |
| store | input | 1 | Request is a store |
| wdata | input | 32 | Register data to store |
| mem_rdata | input | 32 | Word read from memory |
| word_addr | output | ADDR_W-2 | Word address to memory |
| lane_we | output | 4 | Byte-lane write strobes, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-positioned write data |
| load_data | output | 32 | Extracted and extended load result |
| misaligned | output | 1 | Address not a multiple of the size |
| bad_size | output | 1 | Illegal size code |

## Verification
Every size and offset pair is driven as both a store and a load. This separates lane mapping errors (byte order reversed, wrong halfword half) from alignment errors, which show up only at particular offsets. Load words are chosen so that each byte is distinct and the byte tops differ: 0x000F4240, 0x80FF7F01 and 0xDEADBEEF. With these, a wrong lane pick or a wrong fill bit gives a visibly different result under both extension modes. Illegal sizes, store-low requests and wide addresses confirm that the strobes stay quiet and that the word address is the byte address shifted right by two.

// File: rtl/be_lsu_align.sv
module be_lsu_align #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              sign_ext,
  input  logic              store,
  input  logic [31:0]       wdata,
  input  logic [31:0]       mem_rdata,
  output logic [ADDR_W-3:0] word_addr,
  output logic [3:0]        lane_we,
  output logic [31:0]       mem_wdata,
  output logic [31:0]       load_data,
  output logic              misaligned,
  output logic              bad_size
);
  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_H = 2'b01;
  localparam logic [1:0] SZ_W = 2'b10;

  logic [1:0]  off;
  logic        reject;
  logic [3:0]  mask;
  logic [7:0]  rd_byte;
  logic [15:0] rd_half;

  assign off        = addr[1:0];
  assign word_addr  = addr[ADDR_W-1:2];
  assign bad_size   = (size == 2'b11);
  assign misaligned = ((size == SZ_H) && off[0]) || ((size == SZ_W) && (off != 2'b00));
  assign reject     = misaligned || bad_size;

  always_comb begin
    unique case (size)
      SZ_B:    mask = 4'b1000 >> off;
      SZ_H:    mask = off[1] ? 4'b0011 : 4'b1100;
      SZ_W:    mask = 4'b1111;
      default: mask = 4'b0000;
    endcase
  end

  assign lane_we = (store && !reject) ? mask : 4'b0000;

  always_comb begin
    unique case (size)
      SZ_B:    mem_wdata = {4{wdata[7:0]}};
      SZ_H:    mem_wdata = {2{wdata[15:0]}};
      default: mem_wdata = wdata;
    endcase
  end

  always_comb begin
    unique case (off)
      2'd0:    rd_byte = mem_rdata[31:24];
      2'd1:    rd_byte = mem_rdata[23:16];
      2'd2:    rd_byte = mem_rdata[15:8];
      default: rd_byte = mem_rdata[7:0];
    endcase
  end

  assign rd_half = off[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    if (reject)
      load_data = 32'd0;
    else begin
      unique case (size)
        SZ_B:    load_data = {{24{sign_ext & rd_byte[7]}}, rd_byte};
        SZ_H:    load_data = {{16{sign_ext & rd_half[15]}}, rd_half};
        default: load_data = mem_rdata;
      endcase
    end
  end

  always_comb begin
    AST_REJECT_QUIET: assert (!(misaligned || bad_size) || (lane_we == 4'b0000 && load_data == 32'd0)) else $error("reject not quiet"); // R4
    AST_ILLEGAL_NOT_MISALIGNED: assert (!bad_size || !misaligned) else $error("bad size flagged misaligned"); // R3
    AST_NO_STORE_NO_WE: assert (store || lane_we == 4'b0000) else $error("strobe without store"); // R14
    AST_LANE_COUNT: assert (lane_we == 4'b0000 ||
                            $countones(lane_we) == (size == SZ_B ? 1 : size == SZ_H ? 2 : 4)) else $error("lane count"); // R5
    AST_WORD_PASS: assert (size != SZ_W || misaligned || load_data == mem_rdata) else $error("word load altered"); // R13
    AST_UNSIGNED_FILL: assert (sign_ext || size != SZ_B || load_data[31:8] == 24'd0) else $error("unsigned fill"); // R11
  end
endmodule

// File: tb/be_lsu_align_test.sv
module be_lsu_align_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] addr;
  logic [1:0]  size;
  logic        sign_ext, store;
  logic [31:0] wdata, mem_rdata;
  logic [29:0] word_addr;
  logic [3:0]  lane_we;
  logic [31:0] mem_wdata, load_data;
  logic        misaligned, bad_size;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  be_lsu_align #(.ADDR_W(32)) uut (
    .addr(addr), .size(size), .sign_ext(sign_ext), .store(store),
    .wdata(wdata), .mem_rdata(mem_rdata), .word_addr(word_addr),
    .lane_we(lane_we), .mem_wdata(mem_wdata), .load_data(load_data),
    .misaligned(misaligned), .bad_size(bad_size)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] s, input logic sx,
                       input logic st, input logic [31:0] wd, input logic [31:0] rd);
    @(negedge clk);
    addr = a; size = s; sign_ext = sx; store = st; wdata = wd; mem_rdata = rd;
    #1;
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic bit exp_bad(input logic [31:0] a, input logic [1:0] s);
    if (s == 2'b11) return 1'b1;
    return (a % nbytes(s)) != 0;
  endfunction

  function automatic logic [3:0] exp_we(input logic [31:0] a, input logic [1:0] s, input logic st);
    logic [3:0] m = '0;
    int o = int'(a[1:0]);
    if (!st || exp_bad(a, s)) return 4'b0000;
    for (int i = 0; i < 4; i++)
      if (i >= o && i < o + nbytes(s)) m[3-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [31:0] d, input logic [1:0] s);
    logic [31:0] r = '0;
    int n = nbytes(s);
    for (int i = 0; i < 4; i++) begin
      int src = n - 1 - (i % n);
      r[31-8*i -: 8] = d[8*src +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [31:0] a, input logic [1:0] s,
                                         input logic sx, input logic [31:0] rd);
    logic [31:0] v = '0;
    int n = nbytes(s);
    int o = int'(a[1:0]);
    if (exp_bad(a, s)) return 32'd0;
    for (int k = 0; k < n; k++) v = (v << 8) | 32'(rd[31-8*(o+k) -: 8]);
    if (sx && n < 4 && v[8*n-1]) for (int b = 8*n; b < 32; b++) v[b] = 1'b1;
    return v;
  endfunction

  task automatic t_reset;
    apply(32'd0, 2'b00, 1'b0, 1'b0, 32'd0, 32'd0);
    chk("R14 idle strobes", {28'd0, lane_we}, 32'd0);
    chk("R2 idle misaligned", {31'd0, misaligned}, 32'd0);
    chk("R9 idle load", load_data, 32'd0);
  endtask

  task automatic t_store_sweep(input logic [31:0] d);
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        logic [31:0] a = 32'h0000_0050 + 32'(o);
        apply(a, 2'(s), 1'b0, 1'b1, d, 32'd0);
        chk(s == 0 ? "R5 byte strobes" : s == 1 ? "R6 half strobes" : "R7 word strobes",
            {28'd0, lane_we}, {28'd0, exp_we(a, 2'(s), 1'b1)});
        chk("R2 misaligned flag", {31'd0, misaligned}, {31'd0, exp_bad(a, 2'(s))});
        chk("R8 store data", mem_wdata, exp_wd(d, 2'(s)));
        if (exp_bad(a, 2'(s))) chk("R4 reject strobes", {28'd0, lane_we}, 32'd0);
      end
  endtask

  task automatic t_load_sweep(input logic [31:0] rd);
    for (int sx = 0; sx < 2; sx++)
      for (int s = 0; s < 3; s++)
        for (int o = 0; o < 4; o++) begin
          logic [31:0] a = 32'h0000_1000 + 32'(o);
          apply(a, 2'(s), 1'(sx), 1'b0, 32'hFFFF_FFFF, rd);
          chk(s == 2 ? "R13 word load" : s == 1 ? "R10 half load" :
              (sx != 0) ? "R12 signed byte load" : "R11 unsigned byte load",
              load_data, exp_ld(a, 2'(s), 1'(sx), rd));
          chk("R14 load strobes", {28'd0, lane_we}, 32'd0);
        end
  endtask

  task automatic t_example;
    apply(32'd80, 2'b10, 1'b0, 1'b1, 32'h000F_4240, 32'd0);
    chk("R7 example word", mem_wdata, 32'h000F_4240);
    apply(32'd81, 2'b00, 1'b1, 1'b0, 32'd0, 32'h000F_4240);
    chk("R9 example byte 81", load_data, 32'h0000_000F);
    apply(32'd82, 2'b01, 1'b1, 1'b0, 32'd0, 32'h000F_4240);
    chk("R10 example half 82", load_data, 32'h0000_4240);
    apply(32'd83, 2'b00, 1'b1, 1'b0, 32'd0, 32'h8000_00C0);
    chk("R12 sign byte", load_data, 32'hFFFF_FFC0);
  endtask

  task automatic t_illegal;
    for (int o = 0; o < 4; o++) begin
      apply(32'h0000_0200 + 32'(o), 2'b11, 1'b1, 1'b1, 32'h1234_5678, 32'h8765_4321);
      chk("R3 bad_size", {31'd0, bad_size}, 32'd1);
      chk("R3 not misaligned", {31'd0, misaligned}, 32'd0);
      chk("R4 illegal strobes", {28'd0, lane_we}, 32'd0);
      chk("R4 illegal load", load_data, 32'd0);
    end
    apply(32'h0000_0203, 2'b01, 1'b1, 1'b0, 32'd0, 32'hFFFF_FFFF);
    chk("R4 misaligned load", load_data, 32'd0);
    chk("R3 legal bad_size low", {31'd0, bad_size}, 32'd0);
  endtask

  task automatic t_addr;
    logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5B, 32'h8000_0006};
    foreach (pats[i]) begin
      apply(pats[i], 2'b00, 1'b0, 1'b0, 32'd0, 32'd0);
      chk("R1 word address", {2'b00, word_addr}, pats[i] >> 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    addr = '0; size = '0; sign_ext = 1'b0; store = 1'b0; wdata = '0; mem_rdata = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_store_sweep(32'h1122_3344);
    t_store_sweep(32'hCAFE_F00D);
    t_load_sweep(32'h000F_4240);
    t_load_sweep(32'h80FF_7F01);
    t_load_sweep(32'hDEAD_BEEF);
    t_example();
    t_illegal();
    t_addr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule